// File: doc/BRIEF.md
# FM Voice Carrier Output Accumulator

This block sits at the end of a time-multiplexed FM synthesis pipeline. Operator results arrive one per transfer, each tagged with its slot (operator 1 to 4, carried as slot 0 to 3), its voice and the voice's algorithm number. For each voice the block adds only the operators that are carriers under that algorithm. Each carrier is first cut to its top 9 bits, so the result is a 9-bit signed sample for a DAC with 512 codes.

One voice (by default the sixth, index 5) can instead play a directly written sample. That sample is built from an 8-bit data word and a separate least-significant bit that comes from a test register. A second output gives a ladder-corrected code, where a fixed offset is added to negative samples to model the step between the two halves of a resistor-string DAC.

Both the operator input and the sample output are valid/ready streams. A sample is offered after the last slot of its voice is accepted, and it is held until the sink takes it. While a sample is pending and `out_ready` is low, `in_ready` is low, so no operator is accepted and nothing is lost.

Top module: `fm_carrier_acc`

## Requirements
- R1: Each carrier contributes its operator value (14-bit two's complement) arithmetically shifted right by 5, that is, bits 13..5. The 5 low bits are dropped separately on every carrier before the addition, not once on the total.
- R2: Carriers by algorithm number: 0 to 3 use operator 4 only, 4 uses operators 2 and 4, 5 and 6 use operators 2, 3 and 4, and 7 uses all four. Operator n arrives in slot n-1.
- R3: With the default `SATURATE=1`, the sum of the truncated carriers is clamped to +255 and -256 and does not wrap.
- R4: The running sum restarts at slot 0 of every voice. The result is offered on `out_sample` with `out_valid` in the cycle after slot 3 is accepted, and `out_voice` equals the `in_voice` of that slot 3 transfer.
- R5: When `dac_en` is high at the slot 3 transfer of voice `DAC_VOICE` (default 5), the sample is {~dac_data[7], dac_data[6:0], dac_lsb}. This is offset binary turned into two's complement, with `dac_lsb` as bit 0. The operator sum is not used for that voice.
- R6: `dac_en` has no effect on any voice other than `DAC_VOICE`.
- R7: `out_code` equals `out_sample` when the sample is zero or positive. When the sample is negative, `out_code` is the sample plus `NEG_OFFSET`, limited to +255. The offset is applied after clamping.
- R8: After reset `out_valid` is 0 and `in_ready` is 1. While `out_valid` is high and `out_ready` is low, `out_sample`, `out_voice` and `out_valid` hold and `in_ready` is 0.
- R9: Operator values in slots that are not carriers for the voice's algorithm do not change the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operator transfer offered |
| in_ready | output | 1 | Operator transfer can be taken |
| in_op | input | 14 | Signed operator output |
| in_slot | input | 2 | Operator slot, 0 to 3 |
| in_voice | input | 3 | Voice index |
| in_alg | input | 3 | Algorithm number of the voice |
| dac_en | input | 1 | Direct sample mode for voice DAC_VOICE |
| dac_data | input | 8 | Direct sample, offset binary |
| dac_lsb | input | 1 | Ninth, least significant direct sample bit |
| out_valid | output | 1 | Sample offered |
| out_ready | input | 1 | Sink takes the sample |
| out_voice | output | 3 | Voice of the offered sample |
| out_sample | output | 9 | Signed 9-bit sample |
| out_code | output | 9 | Sample after negative-half offset |

## Verification
The bench uses operators that are all -1, and operators that are all 31. With these values, truncating once after the sum gives -1 and 3, where truncating per carrier gives -4 and 0. It drives every algorithm with large values in the modulator slots, so a wrong carrier table shows up as a sum that is too large. Four full-scale carriers of each sign catch an accumulator that wraps instead of clamping. Direct sample mode is tried both on the designated voice and on another voice, to catch a missing voice check or a swapped bit order. The sink stalls at irregular times, so a design that drops or overwrites a held sample loses items from the scoreboard. With a nonzero offset, negative samples that come out unshifted, or positive samples that come out shifted, are reported on `out_code`.

// File: rtl/fm_carrier_acc_pkg.sv
package fm_carrier_acc_pkg;
  localparam int OPS = 4;
  localparam int SLOT_W = $clog2(OPS);
  typedef logic [OPS-1:0] carrier_mask_t;
endpackage

// File: rtl/fm_carrier_map.sv
module fm_carrier_map
  import fm_carrier_acc_pkg::*;
(
  input  logic [2:0]    alg,
  output carrier_mask_t mask
);
  // bit n set: operator n+1 is a carrier
  always_comb begin
    unique case (alg)
      3'd0, 3'd1, 3'd2, 3'd3: mask = 4'b1000;
      3'd4:                   mask = 4'b1010;
      3'd5, 3'd6:             mask = 4'b1110;
      default:                mask = 4'b1111;
    endcase
  end
endmodule

// File: rtl/fm_sum_clip.sv
module fm_sum_clip #(
  parameter int SUM_W    = 11,
  parameter int OUT_W    = 9,
  parameter bit SATURATE = 1'b1
) (
  input  logic signed [SUM_W-1:0] sum_i,
  output logic signed [OUT_W-1:0] clip_o
);
  localparam logic signed [SUM_W-1:0] HI = SUM_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] LO = ~HI;

  generate
    if (SATURATE) begin : g_sat
      always_comb begin
        if (sum_i > HI)      clip_o = HI[OUT_W-1:0];
        else if (sum_i < LO) clip_o = LO[OUT_W-1:0];
        else                 clip_o = sum_i[OUT_W-1:0];
      end
    end else begin : g_wrap
      logic [SUM_W-OUT_W-1:0] unused_hi;
      assign unused_hi = sum_i[SUM_W-1:OUT_W];
      assign clip_o = sum_i[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/fm_ladder_adj.sv
module fm_ladder_adj #(
  parameter int W      = 9,
  parameter int OFFSET = 0
) (
  input  logic signed [W-1:0] sample_i,
  output logic signed [W-1:0] code_o
);
  localparam int EW = W + 2;
  localparam logic signed [EW-1:0] HI = EW'((2 ** (W - 1)) - 1);

  logic signed [EW-1:0] ext;
  logic signed [EW-1:0] shifted;

  assign ext     = {{2{sample_i[W-1]}}, sample_i};
  assign shifted = ext + EW'(OFFSET);

  always_comb begin
    if (!sample_i[W-1])    code_o = sample_i;
    else if (shifted > HI) code_o = HI[W-1:0];
    else                   code_o = shifted[W-1:0];
  end
endmodule

// File: rtl/fm_carrier_acc.sv
module fm_carrier_acc
  import fm_carrier_acc_pkg::*;
#(
  parameter int OP_W       = 14,
  parameter int SMP_W      = 9,
  parameter int VOICE_W    = 3,
  parameter int DAC_VOICE  = 5,
  parameter bit SATURATE   = 1'b1,
  parameter int NEG_OFFSET = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [OP_W-1:0]     in_op,
  input  logic [SLOT_W-1:0]   in_slot,
  input  logic [VOICE_W-1:0]  in_voice,
  input  logic [2:0]          in_alg,
  input  logic                dac_en,
  input  logic [SMP_W-2:0]    dac_data,
  input  logic                dac_lsb,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [VOICE_W-1:0]  out_voice,
  output logic [SMP_W-1:0]    out_sample,
  output logic [SMP_W-1:0]    out_code
);
  localparam int SUM_W = SMP_W + SLOT_W;
  localparam int DROP  = OP_W - SMP_W;
  localparam logic [SLOT_W-1:0]  LAST_SLOT = SLOT_W'(OPS - 1);
  localparam logic [VOICE_W-1:0] DAC_ID    = VOICE_W'(DAC_VOICE);

  carrier_mask_t            mask;
  logic signed [SUM_W-1:0]  acc_q;
  logic signed [SUM_W-1:0]  acc_base;
  logic signed [SUM_W-1:0]  addend;
  logic signed [SUM_W-1:0]  acc_sum;
  logic signed [SMP_W-1:0]  clipped;
  logic signed [SMP_W-1:0]  op_top;
  logic [SMP_W-1:0]         dac_smp;
  logic                     take;
  logic                     last;
  logic                     unused_low;

  assign unused_low = ^in_op[DROP-1:0];

  fm_carrier_map u_map (
    .alg  (in_alg),
    .mask (mask)
  );

  // stall the whole operator stream while a sample waits
  assign in_ready = !(out_valid && !out_ready);
  assign take     = in_valid && in_ready;
  assign last     = (in_slot == LAST_SLOT);

  // truncation on each carrier before the add
  assign op_top   = in_op[OP_W-1:DROP];
  assign acc_base = (in_slot == '0) ? '0 : acc_q;
  assign addend   = mask[in_slot] ? SUM_W'(op_top) : '0;
  assign acc_sum  = acc_base + addend;

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (take) acc_q <= acc_sum;
  end

  fm_sum_clip #(
    .SUM_W    (SUM_W),
    .OUT_W    (SMP_W),
    .SATURATE (SATURATE)
  ) u_clip (
    .sum_i  (acc_sum),
    .clip_o (clipped)
  );

  assign dac_smp = {~dac_data[SMP_W-2], dac_data[SMP_W-3:0], dac_lsb};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_voice  <= '0;
      out_sample <= '0;
    end else if (take && last) begin
      out_valid  <= 1'b1;
      out_voice  <= in_voice;
      out_sample <= (dac_en && in_voice == DAC_ID) ? dac_smp : clipped;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

  fm_ladder_adj #(
    .W      (SMP_W),
    .OFFSET (NEG_OFFSET)
  ) u_ladder (
    .sample_i (out_sample),
    .code_o   (out_code)
  );
endmodule

// File: rtl/fm_carrier_acc_chk.sv
module fm_carrier_acc_chk
  import fm_carrier_acc_pkg::*;
#(
  parameter int SMP_W     = 9,
  parameter int VOICE_W   = 3,
  parameter int DAC_VOICE = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic [SLOT_W-1:0]  in_slot,
  input logic [VOICE_W-1:0] in_voice,
  input logic               dac_en,
  input logic [SMP_W-2:0]   dac_data,
  input logic               dac_lsb,
  input logic               out_valid,
  input logic               out_ready,
  input logic [VOICE_W-1:0] out_voice,
  input logic [SMP_W-1:0]   out_sample,
  input logic [SMP_W-1:0]   out_code
);
  localparam logic [SLOT_W-1:0]  LAST_SLOT = SLOT_W'(OPS - 1);
  localparam logic [VOICE_W-1:0] DAC_ID    = VOICE_W'(DAC_VOICE);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample) && $stable(out_voice)));

  assert_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready && in_slot == LAST_SLOT));

  assert_dac_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_slot == LAST_SLOT && dac_en && in_voice == DAC_ID)
    |=> (out_sample == $past({~dac_data[SMP_W-2], dac_data[SMP_W-3:0], dac_lsb})));

  assert_code_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sample[SMP_W-1]) |-> (out_code == out_sample));

  assert_code_neg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sample[SMP_W-1]) |-> ($signed(out_code) >= $signed(out_sample)));
endmodule

bind fm_carrier_acc fm_carrier_acc_chk #(
  .SMP_W     (SMP_W),
  .VOICE_W   (VOICE_W),
  .DAC_VOICE (DAC_VOICE)
) u_chk (.*);

// File: tb/fm_carrier_acc_bench.sv
module fm_carrier_acc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OFS = 4;

  typedef struct {
    int    v;
    int    s;
    int    c;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [13:0] in_op = '0;
  logic [1:0] in_slot = '0;
  logic [2:0] in_voice = '0;
  logic [2:0] in_alg = '0;
  logic       dac_en = 1'b0;
  logic [7:0] dac_data = '0;
  logic       dac_lsb = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [2:0] out_voice;
  logic [8:0] out_sample;
  logic [8:0] out_code;

  int   n_checks = 0;
  int   n_fail = 0;
  int   cyc = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fm_carrier_acc #(.NEG_OFFSET(OFS)) u_fm_carrier_acc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_slot(in_slot), .in_voice(in_voice), .in_alg(in_alg),
    .dac_en(dac_en), .dac_data(dac_data), .dac_lsb(dac_lsb),
    .out_valid(out_valid), .out_ready(out_ready), .out_voice(out_voice),
    .out_sample(out_sample), .out_code(out_code)
  );

  function automatic int is_carrier(int alg, int slot);
    case (alg)
      0, 1, 2, 3: return (slot == 3) ? 1 : 0;
      4:          return (slot == 1 || slot == 3) ? 1 : 0;
      5, 6:       return (slot >= 1) ? 1 : 0;
      default:    return 1;
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_voice(string req, int voice, int alg, int o0, int o1, int o2, int o3,
                            bit den, int dd, bit dl);
    int ops[4];
    int sum = 0;
    exp_t e;
    ops[0] = o0; ops[1] = o1; ops[2] = o2; ops[3] = o3;
    for (int k = 0; k < 4; k++)
      if (is_carrier(alg, k) != 0) sum += (ops[k] >>> 5);
    if (sum > 255) sum = 255;
    if (sum < -256) sum = -256;
    if (den && voice == 5) begin
      sum = ((dd & 8'hFF) ^ 8'h80) * 2 + int'(dl);
      if (sum > 255) sum -= 512;
    end
    e.v = voice;
    e.s = sum;
    e.c = (sum < 0) ? ((sum + OFS > 255) ? 255 : sum + OFS) : sum;
    e.req = req;
    sb.push_back(e);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_op    = 14'(ops[k]);
      in_slot  = 2'(k);
      in_voice = 3'(voice);
      in_alg   = 3'(alg);
      dac_en   = den;
      dac_data = 8'(dd);
      dac_lsb  = dl;
      #2;
      while (!in_ready) begin
        @(negedge clk);
        #2;
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: sink back-pressure and scoreboard compare
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = !((cyc % 5) == 1 || (cyc % 7) == 3 || (cyc % 11) == 4);
      #1;
      if (rst_n && out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check("R4", "unexpected sample count", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(e.req, "voice", int'(out_voice), e.v);
          check(e.req, "sample", int'($signed(out_sample)), e.s);
          check(e.req == "R7" ? "R7" : {e.req, "/R7"}, "code", int'($signed(out_code)), e.c);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R8", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check("R8", "out_valid after reset", int'(out_valid), 0);
    check("R8", "in_ready after reset", int'(in_ready), 1);

    // R2 each algorithm, R9 large modulators
    send_voice("R2", 0, 0, 5000, -7000, 6000, 800, 0, 0, 0);
    send_voice("R2", 1, 1, -8000, 8000, 3000, -1234, 0, 0, 0);
    send_voice("R2", 2, 2, 100, 200, 300, 4095, 0, 0, 0);
    send_voice("R2", 3, 3, 7777, 7777, 7777, -4096, 0, 0, 0);
    send_voice("R9", 4, 4, 8191, 1000, -8000, 2000, 0, 0, 0);
    send_voice("R2", 0, 5, -8192, 640, 960, -320, 0, 0, 0);
    send_voice("R9", 1, 6, 8191, -700, -700, -700, 0, 0, 0);
    send_voice("R2", 2, 7, 1000, -2000, 3000, -500, 0, 0, 0);
    // R1 per-carrier truncation
    send_voice("R1", 3, 7, -1, -1, -1, -1, 0, 0, 0);
    send_voice("R1", 4, 7, 31, 31, 31, 31, 0, 0, 0);
    send_voice("R1", 5, 4, 0, -33, 0, -33, 0, 0, 0);
    // R3 saturation both ways
    send_voice("R3", 0, 7, 8191, 8191, 8191, 8191, 0, 0, 0);
    send_voice("R3", 1, 7, -8192, -8192, -8192, -8192, 0, 0, 0);
    send_voice("R3", 2, 5, 0, 6000, 6000, 6000, 0, 0, 0);
    // R4 restart after large leftover
    send_voice("R4", 3, 0, 0, 0, 0, 64, 0, 0, 0);
    // R5 direct sample on voice 5
    send_voice("R5", 5, 7, 8191, 8191, 8191, 8191, 1, 8'h80, 1'b1);
    send_voice("R5", 5, 0, 0, 0, 0, 0, 1, 8'h00, 1'b0);
    send_voice("R5", 5, 2, 0, 0, 0, 0, 1, 8'hFF, 1'b1);
    // R6 enable on another voice is ignored
    send_voice("R6", 2, 7, 3200, 3200, -64, 0, 1, 8'h12, 1'b1);
    // R7 negative codes with offset
    send_voice("R7", 4, 0, 0, 0, 0, -32, 0, 0, 0);
    send_voice("R7", 1, 0, 0, 0, 0, -3200, 0, 0, 0);

    while (sb.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R4", "leftover expected samples", sb.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule